// File: doc/BRIEF.md
# Bit-Serial Tagged Fraction Adder

This block adds or subtracts two signed binary fractions that arrive one bit per clock on two serial lines. Words travel in frames of 32 bit times. The first bit time of a frame holds a tag that says whether the word is a plain number or an instruction. The fraction digits follow, lowest weight first, so a single carry bit can ripple forward in time. The final bit time carries the sign. The binary point sits just below the sign, so every word stands for a value in [-1, 1). Results wrap modulo 2 back into that interval.

A one-cycle strobe on `frame_start` marks the tag bit of each frame. The `sub` input picks subtraction and is held steady for the whole frame. The result leaves on `sum_bit` in the same framing, one clock after the inputs. `sum_frame` marks its tag bit. `instr_flag` warns that at least one operand was tagged as an instruction. The only state is one carry bit, a frame position counter and the output registers.

Top module: `tagged_serial_adder`

## Requirements
- R1: A frame is 32 bit times. The bit driven together with a `frame_start` pulse is position 0. The position counter then advances once per clock, and after position 31 it wraps to 0 even without a new strobe.
- R2: Every output lags the inputs by exactly one clock. `sum_frame` is high for one cycle, exactly one clock after `frame_start` was high.
- R3: With `sub`=0, output positions 1..31 hold (A + B) mod 2^31, lowest weight first. The operands A and B are the 31-bit words at input positions 1..31, with position 31 as the two's-complement sign (0 plus, 1 minus). A carry out of position 31 is dropped, so +max + tiny gives -1.
- R4: With `sub`=1 for the whole frame, output positions 1..31 hold (A - B) mod 2^31, with the same layout and wrap-around as R3.
- R5: Output position 0 (the tag) is 0 when both input tags are 0, and 1 when either input tag is 1. Tag value 0 means number and 1 means instruction.
- R6: `instr_flag` goes high one clock after a tag bit time where either input tag is 1, and stays at that value until the next tag bit time. After a frame whose two tags are both 0, it is low.
- R7: A `frame_start` pulse restarts the carry: it is cleared for addition and set for subtraction. Any carry left over from an aborted, partial frame is thrown away.
- R8: While `rst_n` is low, `sum_bit`, `sum_frame` and `instr_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the tag bit time of an input frame |
| sub | input | 1 | 1 selects A - B, 0 selects A + B; held for the frame |
| a_bit | input | 1 | Serial operand A |
| b_bit | input | 1 | Serial operand B |
| sum_bit | output | 1 | Serial result, one clock behind the inputs |
| sum_frame | output | 1 | Marks the tag bit time of the result frame |
| instr_flag | output | 1 | An operand of the current result frame was tagged as an instruction |

## Verification
The bench pushes values across both wrap points of the fraction range. Positive plus positive must turn into -1, and -1 minus the smallest step must turn into the largest positive value; a design that kept the carry out of the sign position, or put the sign at the wrong end, would return a shifted or mis-signed word. It subtracts zero and subtracts a value from itself, which catches a carry preset that is missing or starts one position too early: the result would be off by one LSB or by two. It also aborts a frame that left the carry set and starts a new one. A carry that is not cleared at the strobe shows up as an extra unit in the lowest digit. The tag tests alternate instruction-tagged and number-tagged frames, so a flag that never clears, or a tag that leaks into the fraction, shows up.

// File: rtl/sas_pkg.sv
package sas_pkg;
   // majority of three inputs: carry out of a full adder
   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction
endpackage

// File: rtl/sas_pos_ctr.sv
module sas_pos_ctr #(
   parameter int WORD_W = 32,
   localparam int POS_W = $clog2(WORD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   output logic [POS_W-1:0] cur_pos,
   output logic [POS_W-1:0] pos_q
);
   localparam logic [POS_W-1:0] LAST = POS_W'(WORD_W - 1);
   localparam bit POW2 = ((1 << POS_W) == WORD_W);

   // the strobe names the current bit time as position 0
   assign cur_pos = frame_start ? '0 : pos_q;

   generate
      if (POW2) begin : g_wrap_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pos_q <= '0;
            else        pos_q <= cur_pos + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               pos_q <= '0;
            else if (cur_pos == LAST) pos_q <= '0;
            else                      pos_q <= cur_pos + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sas_bit_cell.sv
module sas_bit_cell
   import sas_pkg::*;
(
   input  logic x,
   input  logic y,
   input  logic inv_y,
   input  logic cin,
   output logic s,
   output logic cout
);
   logic y_eff;
   assign y_eff = y ^ inv_y;
   assign s     = x ^ y_eff ^ cin;
   assign cout  = maj3(x, y_eff, cin);
endmodule

// File: rtl/tagged_serial_adder.sv
module tagged_serial_adder #(
   parameter int WORD_W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic sub,
   input  logic a_bit,
   input  logic b_bit,
   output logic sum_bit,
   output logic sum_frame,
   output logic instr_flag
);
   localparam int POS_W = $clog2(WORD_W);

   initial begin
      if (WORD_W < 3)
         $error("WORD_W must leave room for tag, one digit and sign");
   end

   logic [POS_W-1:0] cur_pos;
   logic [POS_W-1:0] pos_q;
   logic             at_tag;
   logic             carry_q;
   logic             cell_s;
   logic             cell_c;
   logic             tag_any;

   sas_pos_ctr #(.WORD_W(WORD_W)) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .cur_pos     (cur_pos),
      .pos_q       (pos_q)
   );

   assign at_tag  = (cur_pos == '0);
   assign tag_any = a_bit | b_bit;

   sas_bit_cell u_cell (
      .x     (a_bit),
      .y     (b_bit),
      .inv_y (sub),
      .cin   (carry_q),
      .s     (cell_s),
      .cout  (cell_c)
   );

   // tag bit time seeds the carry: 0 for add, 1 for two's-complement subtract
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      carry_q <= 1'b0;
      else if (at_tag) carry_q <= sub;
      else             carry_q <= cell_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_bit    <= 1'b0;
         sum_frame  <= 1'b0;
         instr_flag <= 1'b0;
      end else begin
         sum_bit   <= at_tag ? tag_any : cell_s;
         sum_frame <= frame_start;
         if (at_tag) instr_flag <= tag_any;
      end
   end
endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
   parameter int WORD_W = 32,
   localparam int POS_W = $clog2(WORD_W)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             sub,
   input logic             a_bit,
   input logic             b_bit,
   input logic             sum_bit,
   input logic             sum_frame,
   input logic             instr_flag,
   input logic             carry_q,
   input logic [POS_W-1:0] pos_q
);
   a_r1_pos_restart: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (pos_q == POS_W'(1)));

   a_r2_frame_follow: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> sum_frame);

   a_r2_frame_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> !sum_frame);

   a_r5_tag_number: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !a_bit && !b_bit) |=> !sum_bit);

   a_r5_tag_instr: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && (a_bit || b_bit)) |=> sum_bit);

   a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && (a_bit || b_bit)) |=> instr_flag);

   a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !a_bit && !b_bit) |=> !instr_flag);

   a_r7_carry_seed: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (carry_q == $past(sub)));
endmodule

bind tagged_serial_adder sas_checker #(.WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .sub         (sub),
   .a_bit       (a_bit),
   .b_bit       (b_bit),
   .sum_bit     (sum_bit),
   .sum_frame   (sum_frame),
   .instr_flag  (instr_flag),
   .carry_q     (carry_q),
   .pos_q       (pos_q)
);

// File: tb/sim_tagged_serial_adder.sv
`timescale 1ns/1ps
module sim_tagged_serial_adder;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0;
   logic sub = 1'b0;
   logic a_bit = 1'b0;
   logic b_bit = 1'b0;
   logic sum_bit, sum_frame, instr_flag;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tagged_serial_adder u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sub(sub),
      .a_bit(a_bit), .b_bit(b_bit), .sum_bit(sum_bit),
      .sum_frame(sum_frame), .instr_flag(instr_flag)
   );

   // {sub, a_tag, b_tag, a_frac, b_frac}; frac bit 30 is the sign
   localparam int NV = 10;
   localparam logic [64:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b0, 31'h0000_0001, 31'h0000_0001},
      {1'b0, 1'b0, 1'b0, 31'h3FFF_FFFF, 31'h0000_0001},
      {1'b1, 1'b0, 1'b0, 31'h0000_0000, 31'h0000_0001},
      {1'b1, 1'b0, 1'b0, 31'h4000_0000, 31'h0000_0001},
      {1'b0, 1'b1, 1'b0, 31'h7FFF_FFFF, 31'h7FFF_FFFF},
      {1'b1, 1'b0, 1'b0, 31'h1234_5678, 31'h1234_5678},
      {1'b1, 1'b0, 1'b1, 31'h0ABC_DEF0, 31'h0000_0100},
      {1'b0, 1'b0, 1'b0, 31'h2AAA_AAAA, 31'h1555_5555},
      {1'b1, 1'b1, 1'b1, 31'h5A5A_5A5A, 31'h0000_0000},
      {1'b0, 1'b0, 1'b0, 31'h4000_0000, 31'h4000_0000}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drives one frame; inputs change on falling edges, outputs read there too
   task automatic run_frame(input logic s, input logic at, input logic bt,
                            input logic [30:0] af, input logic [30:0] bf,
                            output logic [30:0] got, output logic gtag,
                            output logic gstrobe, output logic gflag);
      for (int p = 0; p < 32; p++) begin
         @(negedge clk);
         if (p == 1) begin
            gtag = sum_bit;
            gstrobe = sum_frame;
         end else if (p > 1) begin
            got[p-2] = sum_bit;
         end
         frame_start = (p == 0);
         sub   = s;
         a_bit = (p == 0) ? at : af[p-1];
         b_bit = (p == 0) ? bt : bf[p-1];
      end
      @(negedge clk);
      got[30] = sum_bit;
      gflag = instr_flag;
      frame_start = 1'b0;
      a_bit = 1'b0;
      b_bit = 1'b0;
   endtask

   initial begin
      logic [30:0] got, expv;
      logic gtag, gstrobe, gflag;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8", "sum_bit in reset", {31'b0, sum_bit}, 32'd0);
      chk("R8", "sum_frame in reset", {31'b0, sum_frame}, 32'd0);
      chk("R8", "instr_flag in reset", {31'b0, instr_flag}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic vs, vat, vbt;
         logic [30:0] va, vb;
         {vs, vat, vbt, va, vb} = VEC[i];
         expv = vs ? (va - vb) : (va + vb);
         run_frame(vs, vat, vbt, va, vb, got, gtag, gstrobe, gflag);
         chk(vs ? "R4" : "R3", $sformatf("vec %0d fraction", i),
             {1'b0, got}, {1'b0, expv});
         chk("R5", $sformatf("vec %0d tag", i), {31'b0, gtag},
             {31'b0, vat | vbt});
         chk("R6", $sformatf("vec %0d flag", i), {31'b0, gflag},
             {31'b0, vat | vbt});
         chk("R2", $sformatf("vec %0d result strobe", i), {31'b0, gstrobe}, 32'd1);
      end

      // R7: abort a frame with the carry set, then restart with 1 + 1
      for (int p = 0; p < 10; p++) begin
         @(negedge clk);
         frame_start = (p == 0);
         sub = 1'b0;
         a_bit = 1'b1;
         b_bit = (p != 0);
      end
      run_frame(1'b0, 1'b0, 1'b0, 31'h1, 31'h1, got, gtag, gstrobe, gflag);
      chk("R7", "add after aborted frame", {1'b0, got}, 32'd2);
      // R7: subtract after aborted frame must still preset the carry
      for (int p = 0; p < 7; p++) begin
         @(negedge clk);
         frame_start = (p == 0);
         sub = 1'b0;
         a_bit = 1'b1;
         b_bit = 1'b1;
      end
      run_frame(1'b1, 1'b0, 1'b0, 31'h10, 31'h3, got, gtag, gstrobe, gflag);
      chk("R7", "sub after aborted frame", {1'b0, got}, 32'hD);

      // R1: counter wraps without a strobe; second frame rides on the wrap
      run_frame(1'b0, 1'b0, 1'b0, 31'h5, 31'h6, got, gtag, gstrobe, gflag);
      // one idle bit already spent at position 0; drive 31 more idle bits
      for (int p = 1; p < 32; p++) begin
         @(negedge clk);
         a_bit = 1'b0;
         b_bit = 1'b0;
      end
      // next bit time is position 0 again: tag 1 with no strobe
      @(negedge clk);
      a_bit = 1'b1;
      b_bit = 1'b0;
      @(negedge clk);
      chk("R1", "wrap tag output", {31'b0, sum_bit}, 32'd1);
      chk("R1", "no strobe on wrap", {31'b0, sum_frame}, 32'd0);
      a_bit = 1'b0;
      @(negedge clk);
      chk("R6", "flag from wrapped tag", {31'b0, instr_flag}, 32'd1);

      // R8: reset in mid-frame clears outputs
      a_bit = 1'b1;
      b_bit = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8", "sum_bit after mid reset", {31'b0, sum_bit}, 32'd0);
      chk("R8", "flag after mid reset", {31'b0, instr_flag}, 32'd0);
      rst_n = 1'b1;
      a_bit = 1'b0;
      b_bit = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog run did not finish actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule